// File: doc/BRIEF.md
# Omega Multistage Interconnect with Broadcast Elements

This block moves one set of up to N messages per clock from N inputs to N outputs across log2(N) stages of 2x2 switching elements, with N/2 elements in each stage. Every input offers a valid bit, a binary destination index, a broadcast flag and a payload. A unicast message is steered toward its destination one address bit per stage. A broadcast message is copied onto both outputs of every element it crosses, so that when nothing stops it, it reaches every output.

Each element chooses one of four positions for the cycle: `SW_STRAIGHT` (upper to upper, lower to lower), `SW_EXCHANGE` (upper to lower, lower to upper), `SW_BCAST_UP` (upper input to both outputs) or `SW_BCAST_LO` (lower input to both outputs). The choice depends only on the two messages present. When both messages need the same output link, or when a broadcast meets any other message, one message is dropped. A per-input blocked vector travels through the pipeline with the messages. It leaves the network in the same cycle as the outputs of its set, which lets the sender retry. There is one register per stage, so a set comes out log2(N) cycles after it goes in. A new set is accepted on every cycle.

Top module: `omega_net`

## Requirements
- R1: While `rst_n` is low, and on the first rising edge after it, `out_valid` and `out_blocked` are all zero.
- R2: A set of inputs sampled on one rising edge appears on the outputs after the LOGN-th rising edge that follows, counting that edge as the first. A different set can be presented on every cycle.
- R3: A lone unicast from input s with destination d appears only on output d. It carries `out_src` = s (binary index in `out_src[d*LOGN +: LOGN]`) and its own payload in `out_data[d*W +: W]`.
- R4: A lone broadcast from any input appears on all N outputs, and no blocked flag is raised.
- R5: When two unicasts at one element need the same output link, the message on the upper input continues and the message on the lower input is dropped.
- R6: When a broadcast meets a unicast at an element, the unicast continues and the broadcast copy is dropped. When two broadcasts meet, the upper one wins.
- R7: `out_blocked[s]` is 1 exactly when some copy of input s's message was dropped. It is reported with that set's outputs and is never raised for an idle input.
- R8: Two unicasts at one element that need different output links both pass. The identity mapping and every cyclic shift of the destinations are delivered completely.
- R9: An output is valid only when it carries a message from an input that was valid in that set. A set with no valid inputs produces all-idle outputs.
- R10: A broadcast that loses some of its copies downstream still delivers its surviving copies, and its blocked flag is raised.
- R11: Links between stages use the perfect shuffle, which moves link i to position i rotated left by one bit. The same wiring sits in front of the first stage. Stage k (0 first) routes on destination bit LOGN-1-k, where 0 selects the upper output and 1 the lower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Input i carries a message |
| in_bcast | input | N | Message of input i is a broadcast |
| in_dest | input | N*LOGN | Destination index of input i at `[i*LOGN +: LOGN]` |
| in_data | input | N*W | Payload of input i at `[i*W +: W]` |
| out_valid | output | N | Output x carries a message |
| out_src | output | N*LOGN | Input index of the message on output x |
| out_data | output | N*W | Payload on output x |
| out_blocked | output | N | Input i lost at least one copy of its message |

## Verification
The bound checker watches every cycle, using its own delayed copy of the inputs. It checks that each valid output traces back to a valid input and that a unicast only ever lands on its own destination. It also checks that an unblocked unicast is actually delivered, that blocked flags appear only for inputs that sent something, and how lone unicasts and lone broadcasts end up. Which input wins at a contested element (R5, R6), the complete passage of shifts (R8), and the partial delivery of a broadcast (R10) depend on the whole pattern, so only the bench's sweeps show them. The bench compares every pattern against a model that tracks the element and side each message copy occupies, stage by stage.

// File: rtl/omega_pkg.sv
package omega_pkg;

    typedef enum logic [1:0] {
        SW_STRAIGHT = 2'd0,
        SW_EXCHANGE = 2'd1,
        SW_BCAST_UP = 2'd2,
        SW_BCAST_LO = 2'd3
    } sw_pos_e;

    // Position that link i occupies after the perfect shuffle (rotate left by one).
    function automatic int shuffle_pos(input int i, input int logn);
        int mask;
        mask = (1 << logn) - 1;
        return ((i << 1) | (i >> (logn - 1))) & mask;
    endfunction

endpackage

// File: rtl/omega_elem.sv
module omega_elem
    import omega_pkg::*;
#(
    parameter int LOGN  = 3,
    parameter int W     = 8,
    parameter int STAGE = 0
) (
    input  logic [2+2*LOGN+W-1:0] msg_up,
    input  logic [2+2*LOGN+W-1:0] msg_lo,
    output logic [2+2*LOGN+W-1:0] out_up,
    output logic [2+2*LOGN+W-1:0] out_lo,
    output logic                  up_drop,
    output logic                  lo_drop
);
    localparam int MW      = 2 + 2*LOGN + W;
    localparam int DST_LSB = 2;
    localparam int BIT_SEL = DST_LSB + LOGN - 1 - STAGE;

    sw_pos_e         pos;
    logic            a_v, a_bc, a_bit, b_v, b_bc, b_bit;
    logic [MW-1:0]   a_eff, b_eff;

    assign a_v   = msg_up[0];
    assign a_bc  = msg_up[1];
    assign a_bit = msg_up[BIT_SEL];
    assign b_v   = msg_lo[0];
    assign b_bc  = msg_lo[1];
    assign b_bit = msg_lo[BIT_SEL];

    // Position choice and conflict resolution
    always_comb begin
        pos     = SW_STRAIGHT;
        up_drop = 1'b0;
        lo_drop = 1'b0;
        if (a_v && b_v) begin
            if (a_bc && b_bc) begin
                pos     = SW_BCAST_UP;
                lo_drop = 1'b1;
            end else if (a_bc) begin
                up_drop = 1'b1;
                pos     = b_bit ? SW_STRAIGHT : SW_EXCHANGE;
            end else if (b_bc) begin
                lo_drop = 1'b1;
                pos     = a_bit ? SW_EXCHANGE : SW_STRAIGHT;
            end else begin
                pos     = a_bit ? SW_EXCHANGE : SW_STRAIGHT;
                lo_drop = (a_bit == b_bit);
            end
        end else if (a_v) begin
            pos = a_bc ? SW_BCAST_UP : (a_bit ? SW_EXCHANGE : SW_STRAIGHT);
        end else if (b_v) begin
            pos = b_bc ? SW_BCAST_LO : (b_bit ? SW_STRAIGHT : SW_EXCHANGE);
        end
    end

    // Output steering for the chosen position
    always_comb begin
        a_eff    = msg_up;
        a_eff[0] = a_v & ~up_drop;
        b_eff    = msg_lo;
        b_eff[0] = b_v & ~lo_drop;
        unique case (pos)
            SW_STRAIGHT: begin out_up = a_eff; out_lo = b_eff; end
            SW_EXCHANGE: begin out_up = b_eff; out_lo = a_eff; end
            SW_BCAST_UP: begin out_up = a_eff; out_lo = a_eff; end
            SW_BCAST_LO: begin out_up = b_eff; out_lo = b_eff; end
        endcase
    end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int LOGN  = 3,
    parameter int W     = 8,
    parameter int STAGE = 0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [(1<<LOGN)*(2+2*LOGN+W)-1:0] links_in,
    input  logic [(1<<LOGN)-1:0]              blk_in,
    output logic [(1<<LOGN)*(2+2*LOGN+W)-1:0] links_q,
    output logic [(1<<LOGN)-1:0]              blk_q
);
    localparam int N       = 1 << LOGN;
    localparam int HALF    = N / 2;
    localparam int MW      = 2 + 2*LOGN + W;
    localparam int SRC_LSB = 2 + LOGN;

    logic [N-1:0][MW-1:0] sh;
    logic [N-1:0][MW-1:0] el_out;
    logic [HALF-1:0]      up_drop, lo_drop;
    logic [N*MW-1:0]      links_nxt;
    logic [N-1:0]         blk_nxt;

    // Perfect-shuffle wiring into this stage
    for (genvar i = 0; i < N; i++) begin : g_shuffle
        localparam int P = shuffle_pos(i, LOGN);
        assign sh[P] = links_in[i*MW +: MW];
    end

    for (genvar j = 0; j < HALF; j++) begin : g_elem
        omega_elem #(.LOGN(LOGN), .W(W), .STAGE(STAGE)) u_elem (
            .msg_up  (sh[2*j]),
            .msg_lo  (sh[2*j+1]),
            .out_up  (el_out[2*j]),
            .out_lo  (el_out[2*j+1]),
            .up_drop (up_drop[j]),
            .lo_drop (lo_drop[j])
        );
    end

    always_comb begin
        blk_nxt = blk_in;
        for (int j = 0; j < HALF; j++) begin
            if (up_drop[j]) blk_nxt[sh[2*j][SRC_LSB +: LOGN]]   = 1'b1;
            if (lo_drop[j]) blk_nxt[sh[2*j+1][SRC_LSB +: LOGN]] = 1'b1;
        end
        for (int i = 0; i < N; i++) links_nxt[i*MW +: MW] = el_out[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            links_q <= '0;
            blk_q   <= '0;
        end else begin
            links_q <= links_nxt;
            blk_q   <= blk_nxt;
        end
    end

endmodule

// File: rtl/omega_net.sv
module omega_net
    import omega_pkg::*;
#(
    parameter int LOGN = 3,
    parameter int W    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [(1<<LOGN)-1:0]     in_valid,
    input  logic [(1<<LOGN)-1:0]     in_bcast,
    input  logic [(1<<LOGN)*LOGN-1:0] in_dest,
    input  logic [(1<<LOGN)*W-1:0]   in_data,
    output logic [(1<<LOGN)-1:0]     out_valid,
    output logic [(1<<LOGN)*LOGN-1:0] out_src,
    output logic [(1<<LOGN)*W-1:0]   out_data,
    output logic [(1<<LOGN)-1:0]     out_blocked
);
    localparam int N  = 1 << LOGN;
    localparam int MW = 2 + 2*LOGN + W;

    logic [LOGN:0][N*MW-1:0] chain;
    logic [LOGN:0][N-1:0]    bchain;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            chain[0][i*MW +: MW] = {in_data[i*W +: W], LOGN'(i),
                                    in_dest[i*LOGN +: LOGN], in_bcast[i], in_valid[i]};
        end
    end
    assign bchain[0] = '0;

    for (genvar k = 0; k < LOGN; k++) begin : g_stage
        omega_stage #(.LOGN(LOGN), .W(W), .STAGE(k)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .links_in (chain[k]),
            .blk_in   (bchain[k]),
            .links_q  (chain[k+1]),
            .blk_q    (bchain[k+1])
        );
    end

    // Final links: a unicast is only presented where its address points
    always_comb begin
        logic [MW-1:0] fin;
        for (int x = 0; x < N; x++) begin
            fin = chain[LOGN][x*MW +: MW];
            out_valid[x]             = fin[0] & (fin[1] | (fin[2 +: LOGN] == LOGN'(x)));
            out_src[x*LOGN +: LOGN]  = fin[2+LOGN +: LOGN];
            out_data[x*W +: W]       = fin[2+2*LOGN +: W];
        end
    end

    assign out_blocked = bchain[LOGN];

endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
    parameter int LOGN = 3,
    parameter int W    = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [(1<<LOGN)-1:0]      in_valid,
    input logic [(1<<LOGN)-1:0]      in_bcast,
    input logic [(1<<LOGN)*LOGN-1:0] in_dest,
    input logic [(1<<LOGN)*W-1:0]    in_data,
    input logic [(1<<LOGN)-1:0]      out_valid,
    input logic [(1<<LOGN)*LOGN-1:0] out_src,
    input logic [(1<<LOGN)*W-1:0]    out_data,
    input logic [(1<<LOGN)-1:0]      out_blocked
);
    localparam int N = 1 << LOGN;

    // Delay line of the input attributes, aligned with the output registers
    logic [LOGN-1:0][N-1:0]      dv, dbc;
    logic [LOGN-1:0][N*LOGN-1:0] dd;
    logic [N-1:0]                pv, pbc;
    logic [N*LOGN-1:0]           pd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv  <= '0;
            dbc <= '0;
            dd  <= '0;
        end else begin
            dv[0]  <= in_valid;
            dbc[0] <= in_bcast;
            dd[0]  <= in_dest;
            for (int i = 1; i < LOGN; i++) begin
                dv[i]  <= dv[i-1];
                dbc[i] <= dbc[i-1];
                dd[i]  <= dd[i-1];
            end
        end
    end

    assign pv  = dv[LOGN-1];
    assign pbc = dbc[LOGN-1];
    assign pd  = dd[LOGN-1];

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0 && out_blocked == '0));

    // R4
    a_r4_lone_bcast_everywhere: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pv) == 1 && (pv & pbc) != '0) |-> (&out_valid && out_blocked == '0));

    // R3
    a_r3_lone_unicast_single: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pv) == 1 && (pv & pbc) == '0) |-> ($countones(out_valid) == 1 && out_blocked == '0));

    for (genvar x = 0; x < N; x++) begin : g_out
        // R9
        a_r9_output_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[x] |-> pv[out_src[x*LOGN +: LOGN]]);
        // R3
        a_r3_unicast_on_dest: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[x] && !pbc[out_src[x*LOGN +: LOGN]])
            |-> (pd[out_src[x*LOGN +: LOGN]*LOGN +: LOGN] == LOGN'(x)));
    end

    for (genvar s = 0; s < N; s++) begin : g_src
        // R7
        a_r7_blocked_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
            out_blocked[s] |-> pv[s]);
        // R7
        a_r7_unblocked_delivered: assert property (@(posedge clk) disable iff (!rst_n)
            (pv[s] && !pbc[s] && !out_blocked[s])
            |-> (out_valid[pd[s*LOGN +: LOGN]] &&
                 out_src[pd[s*LOGN +: LOGN]*LOGN +: LOGN] == LOGN'(s)));
    end

endmodule

bind omega_net omega_net_chk #(.LOGN(LOGN), .W(W)) u_chk (.*);

// File: tb/test_omega_net.sv
`timescale 1ns/1ps
module test_omega_net;
    localparam int LOGN  = 3;
    localparam int W     = 8;
    localparam int N     = 1 << LOGN;
    localparam int NPAT  = 387;
    localparam int RING  = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [N-1:0]        in_valid = '0, in_bcast = '0;
    logic [N*LOGN-1:0]   in_dest = '0;
    logic [N*W-1:0]      in_data = '0;
    logic [N-1:0]        out_valid, out_blocked;
    logic [N*LOGN-1:0]   out_src;
    logic [N*W-1:0]      out_data;

    int total = 0, bad = 0;

    always #2 clk = ~clk;

    omega_net #(.LOGN(LOGN), .W(W)) i_omega_net (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bcast(in_bcast),
        .in_dest(in_dest), .in_data(in_data), .out_valid(out_valid),
        .out_src(out_src), .out_data(out_data), .out_blocked(out_blocked)
    );

    // Current pattern
    bit       t_v [N];
    bit       t_bc [N];
    int       t_dest [N];
    int       t_data [N];
    string    t_req;
    bit [31:0] rng = 32'h1234_5678;

    // Expected results ring
    bit       r_v   [RING][N];
    int       r_src [RING][N];
    int       r_dat [RING][N];
    bit [N-1:0] r_blk [RING];
    string    r_req [RING];

    function automatic bit [31:0] next_rand(input bit [31:0] x);
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic gen(input int p);
        for (int s = 0; s < N; s++) begin
            t_v[s] = 0; t_bc[s] = 0; t_dest[s] = 0;
            t_data[s] = (s*29 + p*7 + 3) & 8'hFF;
        end
        t_req = "R9";
        if (p >= 1 && p <= 64) begin
            t_v[(p-1)/N] = 1; t_dest[(p-1)/N] = (p-1)%N; t_req = "R3 R11";
        end else if (p >= 65 && p <= 72) begin
            t_v[p-65] = 1; t_bc[p-65] = 1; t_req = "R4";
        end else if (p >= 73 && p <= 80) begin
            for (int s = 0; s < N; s++) begin t_v[s] = 1; t_dest[s] = (s + p - 73) % N; end
            t_req = "R8";
        end else if (p == 81) begin
            for (int s = 0; s < N; s++) begin
                t_v[s] = 1;
                t_dest[s] = ((s&1)<<2) | (s&2) | ((s>>2)&1);
            end
            t_req = "R5";
        end else if (p == 82) begin
            t_v[0] = 1; t_dest[0] = 5; t_v[6] = 1; t_dest[6] = 4; t_req = "R5";
        end else if (p == 83) begin
            t_v[1] = 1; t_bc[1] = 1; t_v[5] = 1; t_dest[5] = 2; t_req = "R6";
        end else if (p == 84) begin
            t_v[1] = 1; t_dest[1] = 6; t_v[5] = 1; t_bc[5] = 1; t_req = "R6";
        end else if (p == 85) begin
            t_v[0] = 1; t_bc[0] = 1; t_v[4] = 1; t_bc[4] = 1; t_req = "R6";
        end else if (p == 86) begin
            t_v[0] = 1; t_bc[0] = 1; t_v[1] = 1; t_dest[1] = 6; t_req = "R10";
        end else if (p >= 87 && p < NPAT) begin
            for (int s = 0; s < N; s++) begin
                rng = next_rand(rng);
                t_v[s]    = rng[0] | rng[1];
                t_bc[s]   = (rng[4:2] == 3'd0);
                t_dest[s] = int'(rng[7:5]);
            end
            t_req = "R5 R6 R7";
        end
    endtask

    // Stage-by-stage occupancy model: copy x of source s sits at element
    // ((s<<k)|x) mod N/2 on side bit (LOGN-1-k) of s.
    task automatic model(input int slot);
        bit [N-1:0] live [N];
        bit [N-1:0] nlive [N];
        bit         occ_v [N];
        int         occ_s [N];
        int         occ_x [N];
        bit [N-1:0] blk;
        blk = '0;
        for (int s = 0; s < N; s++) begin live[s] = '0; live[s][0] = t_v[s]; end
        for (int k = 0; k < LOGN; k++) begin
            for (int i = 0; i < N; i++) occ_v[i] = 0;
            for (int s = 0; s < N; s++)
                for (int x = 0; x < (1 << k); x++)
                    if (live[s][x]) begin
                        int e, sd;
                        e  = ((s << k) | x) & (N/2 - 1);
                        sd = (s >> (LOGN-1-k)) & 1;
                        occ_v[e*2+sd] = 1; occ_s[e*2+sd] = s; occ_x[e*2+sd] = x;
                    end
            for (int e = 0; e < N/2; e++)
                if (occ_v[2*e] && occ_v[2*e+1]) begin
                    int u, l, lose;
                    u = occ_s[2*e]; l = occ_s[2*e+1]; lose = -1;
                    if (t_bc[u] && t_bc[l])      lose = 2*e+1;
                    else if (t_bc[u])            lose = 2*e;
                    else if (t_bc[l])            lose = 2*e+1;
                    else if (((t_dest[u] >> (LOGN-1-k)) & 1) == ((t_dest[l] >> (LOGN-1-k)) & 1))
                        lose = 2*e+1;
                    if (lose >= 0) begin
                        live[occ_s[lose]][occ_x[lose]] = 0;
                        blk[occ_s[lose]] = 1;
                    end
                end
            for (int s = 0; s < N; s++) begin
                nlive[s] = '0;
                for (int x = 0; x < (1 << k); x++)
                    if (live[s][x]) begin
                        if (t_bc[s]) begin nlive[s][2*x] = 1; nlive[s][2*x+1] = 1; end
                        else nlive[s][2*x + ((t_dest[s] >> (LOGN-1-k)) & 1)] = 1;
                    end
            end
            for (int s = 0; s < N; s++) live[s] = nlive[s];
        end
        for (int x = 0; x < N; x++) begin
            r_v[slot][x] = 0; r_src[slot][x] = 0; r_dat[slot][x] = 0;
            for (int s = 0; s < N; s++)
                if (live[s][x]) begin
                    r_v[slot][x] = 1; r_src[slot][x] = s; r_dat[slot][x] = t_data[s];
                end
        end
        r_blk[slot] = blk;
        r_req[slot] = t_req;
    endtask

    task automatic drive();
        for (int s = 0; s < N; s++) begin
            in_valid[s]             = t_v[s];
            in_bcast[s]             = t_bc[s];
            in_dest[s*LOGN +: LOGN] = LOGN'(t_dest[s]);
            in_data[s*W +: W]       = W'(t_data[s]);
        end
    endtask

    task automatic check_slot(input int slot);
        for (int x = 0; x < N; x++) begin
            int as, ad;
            as = int'(out_src[x*LOGN +: LOGN]);
            ad = int'(out_data[x*W +: W]);
            total++;
            if (out_valid[x] !== r_v[slot][x] ||
                (r_v[slot][x] && (as != r_src[slot][x] || ad != r_dat[slot][x]))) begin
                bad++;
                $display("FAIL %s R2 out%0d: valid=%0b src=%0d data=%0h expected valid=%0b src=%0d data=%0h",
                         r_req[slot], x, out_valid[x], as, ad,
                         r_v[slot][x], r_src[slot][x], r_dat[slot][x]);
            end
        end
        total++;
        if (out_blocked !== r_blk[slot]) begin
            bad++;
            $display("FAIL %s R7 blocked=%b expected %b", r_req[slot], out_blocked, r_blk[slot]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (out_valid !== '0 || out_blocked !== '0) begin
            bad++;
            $display("FAIL R1 in reset: valid=%b blocked=%b expected 0 0", out_valid, out_blocked);
        end
        rst_n = 1'b1;
        for (int m = 0; m < NPAT + LOGN; m++) begin
            @(negedge clk);
            if (m >= LOGN) check_slot((m - LOGN) % RING);
            gen(m < NPAT ? m : 0);
            drive();
            model(m % RING);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule